// File: doc/BRIEF.md
# Run-Time Configurable CRC Engine

This block keeps a running cyclic redundancy check over a stream of data words. Inside it sits a cascade of one-bit update stages. In the default parallel build, every data bit of a word passes through the cascade in the same clock, so one word is absorbed per accepted strobe. A build parameter can instead select a serial build. That build holds one stage and absorbs the captured word one bit per clock. It shows that it is occupied through a busy output.

The generator polynomial is a plain input, so it can change between words. A narrower CRC is run inside the full register by aligning its polynomial to the top bits and setting a width-select vector. Each set bit of that vector clears one low register position before it shifts. A build-time mask states which of those positions may be cleared at all. A load strobe places a seed value in the register. The current register value is always visible at the output.

Top module: `crc_prog_engine`

## Requirements
- R1: While the active-low asynchronous reset is asserted, the CRC output is zero and busy is low.
- R2: A load strobe writes the seed into the CRC register at the next clock edge. It overrides an accepted data strobe in the same cycle, and in the serial build it also abandons any word in progress and clears busy.
- R3: With no load, no accepted data strobe and no word in progress, the CRC register holds its value.
- R4: A single bit step computes feedback = register MSB XOR data bit. The register then shifts up one place, and every bit above bit 0 is XORed with the matching polynomial bit ANDed with the feedback. The new bit 0 is polynomial bit 0 ANDed with the feedback. Word bits are taken from the MSB down. With polynomial 0x07, full width and seed 0, the bytes of ASCII "123456789" give 0xF4.
- R5: Bit j of the width-select input (CRC_W-1 bits) clears register bit CRC_W-2-j before each shift, when bit j of the build mask is also set. For a k-bit CRC, the polynomial is shifted up by CRC_W-k and select bits CRC_W-2 down to k-1 are set. The top k output bits then equal a plain k-bit CRC, and the low bits are zero after any word, whatever low bits the seed held.
- R6: The polynomial applies to the word folded in the cycle it is presented, so a new polynomial takes effect on the very next word.
- R7: In the serial build, an accepted word raises busy for exactly DATA_W cycles. When busy falls, the register holds the same value a parallel build would give for that word.
- R8: In the serial build, a data strobe that arrives while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Write the seed into the CRC register |
| seed_i | input | CRC_W | Seed value |
| valid_i | input | 1 | Data word strobe |
| data_i | input | DATA_W | Data word, MSB processed first |
| poly_i | input | CRC_W | Generator polynomial, implicit top term omitted |
| size_sel_i | input | CRC_W-1 | Width select, reversed bit order against register positions |
| crc_o | output | CRC_W | Current CRC register |
| busy_o | output | 1 | Serial build: word in progress (always low in the parallel build) |

## Verification
Two functions can meet in one cycle. One is a seed load arriving with a data strobe. The other, in the serial build, is a load or a new strobe arriving while a word is still being shifted. The bench drives one shared stimulus into a parallel instance and a serial instance. It raises load and valid together on purpose, and it fires strobes and loads in the middle of a serial run. Its behavioural models give load priority and drop strobes that arrive while busy. Register values and busy are then compared against those models on every clock.

// File: rtl/crcpe_pkg.sv
package crcpe_pkg;
   // counter width able to hold the value n
   function automatic int cnt_bits(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/crcpe_bit_step.sv
module crcpe_bit_step #(
   parameter int              CRC_W     = 8,
   parameter logic [CRC_W-2:0] SIZE_MASK = '1
) (
   input  logic              bit_i,
   input  logic [CRC_W-1:0]  crc_i,
   input  logic [CRC_W-1:0]  poly_i,
   input  logic [CRC_W-2:0]  size_sel_i,
   output logic [CRC_W-1:0]  crc_o
);
   logic             fb;
   logic [CRC_W-1:0] taps;
   logic [CRC_W-2:0] kept;

   assign fb   = crc_i[CRC_W-1] ^ bit_i;
   assign taps = poly_i & {CRC_W{fb}};

   // low register bit i is dropped when its reversed select bit is enabled
   for (genvar i = 0; i < CRC_W - 1; i++) begin : g_keep
      if (SIZE_MASK[CRC_W-2-i]) begin : g_sel
         assign kept[i] = crc_i[i] & ~size_sel_i[CRC_W-2-i];
      end else begin : g_fixed
         assign kept[i] = crc_i[i];
      end
   end

   assign crc_o = {kept ^ taps[CRC_W-1:1], taps[0]};
endmodule

// File: rtl/crcpe_chain.sv
module crcpe_chain #(
   parameter int              CRC_W     = 8,
   parameter int              N_BITS    = 8,
   parameter logic [CRC_W-2:0] SIZE_MASK = '1
) (
   input  logic [N_BITS-1:0] bits_i,
   input  logic [CRC_W-1:0]  crc_i,
   input  logic [CRC_W-1:0]  poly_i,
   input  logic [CRC_W-2:0]  size_sel_i,
   output logic [CRC_W-1:0]  crc_o
);
   logic [CRC_W-1:0] link [0:N_BITS];

   assign link[0] = crc_i;

   // stage k consumes bit N_BITS-1-k, so the MSB goes first
   for (genvar k = 0; k < N_BITS; k++) begin : g_stage
      crcpe_bit_step #(
         .CRC_W    (CRC_W),
         .SIZE_MASK(SIZE_MASK)
      ) u_step (
         .bit_i     (bits_i[N_BITS-1-k]),
         .crc_i     (link[k]),
         .poly_i    (poly_i),
         .size_sel_i(size_sel_i),
         .crc_o     (link[k+1])
      );
   end

   assign crc_o = link[N_BITS];
endmodule

// File: rtl/crcpe_serial_seq.sv
module crcpe_serial_seq #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              valid_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              bit_o,
   output logic              step_o,
   output logic              busy_o
);
   localparam int CNT_W = crcpe_pkg::cnt_bits(DATA_W);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

   logic [DATA_W-1:0] shift_q;
   logic [CNT_W-1:0]  left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         left_q  <= '0;
      end else if (load_i) begin
         left_q <= '0;
      end else if (left_q != '0) begin
         left_q  <= left_q - 1'b1;
         shift_q <= shift_q << 1;
      end else if (valid_i) begin
         shift_q <= data_i;
         left_q  <= CNT_FULL;
      end
   end

   assign busy_o = (left_q != '0);
   assign step_o = busy_o & ~load_i;
   assign bit_o  = shift_q[DATA_W-1];
endmodule

// File: rtl/crc_prog_engine.sv
module crc_prog_engine #(
   parameter int              CRC_W     = 8,
   parameter int              DATA_W    = 8,
   parameter logic [CRC_W-2:0] SIZE_MASK = '1,
   parameter bit              SERIAL    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [CRC_W-1:0]  seed_i,
   input  logic              valid_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [CRC_W-1:0]  poly_i,
   input  logic [CRC_W-2:0]  size_sel_i,
   output logic [CRC_W-1:0]  crc_o,
   output logic              busy_o
);
   localparam int STAGES = SERIAL ? 1 : DATA_W;

   if (CRC_W < 2) begin : g_bad_crc_w
      $error("crc_prog_engine: CRC_W must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("crc_prog_engine: DATA_W must be at least 1");
   end

   logic [CRC_W-1:0]  crc_q;
   logic [CRC_W-1:0]  crc_next;
   logic [STAGES-1:0] feed_bits;
   logic              advance;

   if (SERIAL) begin : g_serial
      logic ser_bit;
      logic ser_step;
      logic ser_busy;

      crcpe_serial_seq #(.DATA_W(DATA_W)) u_seq (
         .clk    (clk),
         .rst_n  (rst_n),
         .load_i (load_i),
         .valid_i(valid_i),
         .data_i (data_i),
         .bit_o  (ser_bit),
         .step_o (ser_step),
         .busy_o (ser_busy)
      );
      assign feed_bits = ser_bit;
      assign advance   = ser_step;
      assign busy_o    = ser_busy;
   end else begin : g_parallel
      assign feed_bits = data_i;
      assign advance   = valid_i;
      assign busy_o    = 1'b0;
   end

   crcpe_chain #(
      .CRC_W    (CRC_W),
      .N_BITS   (STAGES),
      .SIZE_MASK(SIZE_MASK)
   ) u_chain (
      .bits_i    (feed_bits),
      .crc_i     (crc_q),
      .poly_i    (poly_i),
      .size_sel_i(size_sel_i),
      .crc_o     (crc_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       crc_q <= '0;
      else if (load_i)  crc_q <= seed_i;
      else if (advance) crc_q <= crc_next;
   end

   assign crc_o = crc_q;
endmodule

// File: rtl/crcpe_chk.sv
module crcpe_chk #(
   parameter int CRC_W  = 8,
   parameter int DATA_W = 8,
   parameter bit SERIAL = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_i,
   input logic [CRC_W-1:0]  seed_i,
   input logic              valid_i,
   input logic [CRC_W-1:0]  poly_i,
   input logic [CRC_W-1:0]  crc_o,
   input logic              busy_o
);
   // R2
   seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> crc_o == $past(seed_i));

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !valid_i && !busy_o) |=> $stable(crc_o));

   // R4
   lsb_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!SERIAL && !load_i && valid_i && !poly_i[0]) |=> crc_o[0] == 1'b0);

   // R7
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(valid_i) && !$past(load_i));
endmodule

bind crc_prog_engine crcpe_chk #(
   .CRC_W (CRC_W),
   .DATA_W(DATA_W),
   .SERIAL(SERIAL)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .load_i (load_i),
   .seed_i (seed_i),
   .valid_i(valid_i),
   .poly_i (poly_i),
   .crc_o  (crc_o),
   .busy_o (busy_o)
);

// File: tb/sim_crc_prog_engine.sv
`timescale 1ns/1ps
module sim_crc_prog_engine;
   localparam int CW = 8;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load = 1'b0;
   logic [CW-1:0] seed = '0;
   logic          valid = 1'b0;
   logic [DW-1:0] data = '0;
   logic [CW-1:0] poly = 8'h07;
   logic [CW-2:0] sel = '0;
   int            width_k = 8;
   logic [CW-1:0] crc0, crc1;
   logic          busy0, busy1;

   int    checks = 0;
   int    failures = 0;
   string req = "R1";
   bit    finished = 1'b0;

   always #10 clk = ~clk;

   crc_prog_engine #(.CRC_W(CW), .DATA_W(DW), .SERIAL(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .load_i(load), .seed_i(seed), .valid_i(valid),
      .data_i(data), .poly_i(poly), .size_sel_i(sel), .crc_o(crc0), .busy_o(busy0));

   crc_prog_engine #(.CRC_W(CW), .DATA_W(DW), .SERIAL(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .load_i(load), .seed_i(seed), .valid_i(valid),
      .data_i(data), .poly_i(poly), .size_sel_i(sel), .crc_o(crc1), .busy_o(busy1));

   // plain k-bit CRC, top aligned in the CW-bit register
   function automatic logic [CW-1:0] fold_word(input logic [CW-1:0] c,
         input logic [DW-1:0] w, input logic [CW-1:0] p, input int k);
      int sh = CW - k;
      int r  = int'(c) >> sh;
      int pk = int'(p) >> sh;
      int msk = (1 << k) - 1;
      for (int b = DW - 1; b >= 0; b--) begin
         bit fb = ((r >> (k - 1)) & 1) != (w[b] ? 1 : 0);
         r = (r << 1) & msk;
         if (fb) r = r ^ pk;
      end
      return CW'(r << sh);
   endfunction

   // reference models
   logic [CW-1:0] exp0, exp1;
   logic [DW-1:0] held1;
   int            left1;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp0 <= '0; exp1 <= '0; left1 <= 0; held1 <= '0;
      end else begin
         if (load) exp0 <= seed;
         else if (valid) exp0 <= fold_word(exp0, data, poly, width_k);
         if (load) begin
            exp1 <= seed; left1 <= 0;
         end else if (left1 != 0) begin
            left1 <= left1 - 1;
            if (left1 == 1) exp1 <= fold_word(exp1, held1, poly, width_k);
         end else if (valid) begin
            held1 <= data; left1 <= DW;
         end
      end
   end

   task automatic check(input string r, input string what, input int got, input int want);
      checks++;
      if (got != want) begin
         failures++;
         $display("FAIL %s %s: got %h expected %h", r, what, got, want);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(req, "u0 crc", int'(crc0), int'(exp0));
         check(req, "u0 busy", int'(busy0), 0);
         check(req, "u1 busy", int'(busy1), int'(left1 != 0));
         if (left1 == 0) check(req, "u1 crc", int'(crc1), int'(exp1));
      end
   end

   task automatic drive(input bit ld, input logic [CW-1:0] sd, input bit v, input logic [DW-1:0] d);
      @(negedge clk);
      load = ld; seed = sd; valid = v; data = d;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, '0, 1'b0, '0);
   endtask

   task automatic set_width(input int k, input logic [CW-1:0] p_k);
      @(negedge clk);
      width_k = k;
      poly = p_k << (CW - k);
      sel  = ((CW-1)'((1 << (CW - 1)) - 1)) & ~((CW-1)'((1 << (k - 1)) - 1));
   endtask

   task automatic serial_word(input logic [DW-1:0] d);
      drive(1'b0, '0, 1'b1, d);
      drive(1'b0, '0, 1'b0, '0);
      while (busy1) drive(1'b0, '0, 1'b0, '0);
   endtask

   initial begin
      string txt = "123456789";
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1", "u0 crc in reset", int'(crc0), 0);
      check("R1", "u1 crc in reset", int'(crc1), 0);
      check("R1", "u1 busy in reset", int'(busy1), 0);
      @(negedge clk); rst_n = 1'b1;

      // R4 known answer, parallel, back to back
      req = "R4";
      drive(1'b1, 8'h00, 1'b0, '0);
      for (int i = 0; i < 9; i++) drive(1'b0, '0, 1'b1, txt[i]);
      drive(1'b0, '0, 1'b0, '0);
      check("R4", "u0 check value 123456789", int'(crc0), 'hF4);

      // R7 known answer, serial
      req = "R7";
      drive(1'b1, 8'h00, 1'b0, '0);
      for (int i = 0; i < 9; i++) serial_word(txt[i]);
      check("R7", "u1 check value 123456789", int'(crc1), 'hF4);

      // R7 busy length: exactly DW cycles
      drive(1'b0, '0, 1'b1, 8'hA5);
      begin
         int n = 0;
         drive(1'b0, '0, 1'b0, '0);
         while (busy1 && n < 100) begin n++; drive(1'b0, '0, 1'b0, '0); end
         check("R7", "u1 busy cycles", n, DW);
      end

      // R3 hold
      req = "R3";
      idle(5);

      // R4 random words and seeds, random gaps
      req = "R4";
      for (int j = 0; j < 30; j++) begin
         if (j % 6 == 0) drive(1'b1, 8'($urandom), 1'b0, '0);
         drive(1'b0, '0, 1'b1, 8'($urandom));
         idle($urandom_range(0, 2));
      end

      // R2 load together with valid
      req = "R2";
      idle(10);
      drive(1'b1, 8'h3C, 1'b1, 8'hFF);
      drive(1'b0, '0, 1'b0, '0);
      check("R2", "u0 load beats valid", int'(crc0), 'h3C);
      check("R2", "u1 load beats valid", int'(crc1), 'h3C);
      check("R2", "u1 not busy after load+valid", int'(busy1), 0);

      // R8 strobes during serial run ignored; R2 load abandons run
      req = "R8";
      drive(1'b0, '0, 1'b1, 8'h5A);
      for (int i = 0; i < 4; i++) drive(1'b0, '0, 1'b1, 8'($urandom));
      idle(DW);
      req = "R2";
      drive(1'b0, '0, 1'b1, 8'hC3);
      idle(3);
      drive(1'b1, 8'h81, 1'b0, '0);
      drive(1'b0, '0, 1'b0, '0);
      check("R2", "u1 load mid run", int'(crc1), 'h81);
      check("R2", "u1 busy cleared by load", int'(busy1), 0);

      // R6 polynomial changes between words
      req = "R6";
      for (int j = 0; j < 12; j++) begin
         @(negedge clk);
         poly = (j % 2 == 0) ? 8'h31 : 8'h9B;
         load = 1'b0; valid = 1'b0;
         serial_word(8'($urandom));
      end

      // R5 reduced widths with garbage in seed low bits
      req = "R5";
      set_width(5, 8'h05);
      for (int j = 0; j < 10; j++) begin
         drive(1'b1, 8'($urandom) | 8'h07, 1'b0, '0);
         serial_word(8'($urandom));
         check("R5", "u0 low bits zero, k=5", int'(crc0 & 8'h07), 0);
      end
      set_width(3, 8'h03);
      for (int j = 0; j < 10; j++) begin
         drive(1'b1, 8'($urandom) | 8'h1F, 1'b0, '0);
         serial_word(8'($urandom));
         check("R5", "u1 low bits zero, k=3", int'(crc1 & 8'h1F), 0);
      end
      idle(2);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(20 * 20000);
      if (!finished) begin
         finished = 1'b1;
         checks++; failures++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule